// File: doc/BRIEF.md
# Graded-Block Carry-Select Adder

This block adds two 32-bit unsigned operands and a single carry input, producing a 32-bit sum and a carry output, with no clock and no storage. The operand width is cut into four segments that grow by two bits from the least significant end: 5, 7, 9 and 11 bits. The bottom segment is a plain ripple adder fed by the external carry. Each higher segment runs two ripple adders side by side. One assumes the incoming carry is 0 and the other assumes it is 1. The real carry from the segment beneath then steers a two-way multiplexer that forwards the matching partial sum and segment carry.

Segment widths grow because the carry that reaches a higher segment has passed through more logic before it gets there. A wider segment uses that extra time to finish both trial additions, so its trial results and its select carry arrive at the multiplexer at about the same moment. The segment layout comes from three package parameters: base width, width step and segment count. A generate loop builds the chain from these, and the data width follows from them.

The block has no control flow and no states; it is a pure function of its three inputs.

Top module: `vbcs_adder`

## Requirements
- R1: `{carry_out, total}` equals the 33-bit value `opnd_x + opnd_y + carry_in`, with both operands treated as unsigned.
- R2: `total[4:0]` equals the low five bits of `opnd_x[4:0] + opnd_y[4:0] + carry_in`. This lowest segment depends only on those inputs.
- R3: For each upper segment (bits [11:5], [20:12], [31:21]), the sum bits equal that segment's operand bits added with the true carry coming out of all the bits below it.
- R4: `carry_out` equals the carry leaving bit 31, which is the selected carry of the top segment [31:21].
- R5: An all-ones operand plus one wraps to a total of 0 with `carry_out` = 1. This holds whether the one comes from `carry_in` or from the other operand.
- R6: Zero operands with `carry_in` = 0 give a total of 0 and `carry_out` = 0. With `carry_in` = 1 they give a total of 1 and `carry_out` = 0.
- R7: A carry produced in the bits below a segment boundary (bit 5, 12 or 21) reaches that boundary. For an operand with bits [b-1:0] all ones plus one, the total is exactly 2^b.
- R8: The outputs are purely combinational. A new result is valid in the same cycle the inputs change, with no register between input and output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_x | input | 32 | First addend |
| opnd_y | input | 32 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| total | output | 32 | Sum bits |
| carry_out | output | 1 | Carry out of bit 31 |

## Verification
Every result is due zero cycles after its stimulus, because no register lies on any path. The bench applies new operands just after a rising clock edge and reads the sum and carry at the following falling edge. Half a period is left for the combinational logic to settle, and no value is ever read across a clock edge. The checker attached to the top module tests the same relations on every input change, once the logic has settled.

// File: rtl/vbcs_pkg.sv
package vbcs_pkg;

    // Segment layout: widths grow by SEG_STEP from the least significant end.
    localparam int SEG_BASE = 5;
    localparam int SEG_STEP = 2;
    localparam int SEG_NUM  = 4;

    // Width of segment idx.
    function automatic int seg_width(input int idx);
        return SEG_BASE + SEG_STEP * idx;
    endfunction

    // Lowest bit position of segment idx.
    function automatic int seg_lsb(input int idx);
        return SEG_BASE * idx + (SEG_STEP * idx * (idx - 1)) / 2;
    endfunction

    localparam int DATA_W = seg_lsb(SEG_NUM);

endpackage

// File: rtl/vbcs_ripple.sv
module vbcs_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);

    logic [W:0] chain;

    assign chain[0] = ci;

    for (genvar k = 0; k < W; k++) begin : g_bit
        logic half;
        assign half       = a[k] ^ b[k];
        assign s[k]       = half ^ chain[k];
        assign chain[k+1] = (a[k] & b[k]) | (half & chain[k]);
    end

    assign co = chain[W];

endmodule

// File: rtl/vbcs_select_seg.sv
module vbcs_select_seg #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel_carry,
    output logic [W-1:0] s,
    output logic         co
);

    logic [W-1:0] trial_s0;
    logic [W-1:0] trial_s1;
    logic         trial_c0;
    logic         trial_c1;

    // Trial assuming the incoming carry is 0.
    vbcs_ripple #(.W(W)) u_trial0 (
        .a  (a),
        .b  (b),
        .ci (1'b0),
        .s  (trial_s0),
        .co (trial_c0)
    );

    // Trial assuming the incoming carry is 1.
    vbcs_ripple #(.W(W)) u_trial1 (
        .a  (a),
        .b  (b),
        .ci (1'b1),
        .s  (trial_s1),
        .co (trial_c1)
    );

    assign s  = sel_carry ? trial_s1 : trial_s0;
    assign co = sel_carry ? trial_c1 : trial_c0;

endmodule

// File: rtl/vbcs_adder.sv
module vbcs_adder
    import vbcs_pkg::*;
(
    input  logic [31:0] opnd_x,
    input  logic [31:0] opnd_y,
    input  logic        carry_in,
    output logic [31:0] total,
    output logic        carry_out
);

    // Carry entering each segment; seg_carry[SEG_NUM] leaves the top one.
    logic [SEG_NUM:0] seg_carry;

    assign seg_carry[0] = carry_in;

    for (genvar i = 0; i < SEG_NUM; i++) begin : g_seg
        localparam int LSB = seg_lsb(i);
        localparam int W   = seg_width(i);

        if (i == 0) begin : g_base
            vbcs_ripple #(.W(W)) u_ripple (
                .a  (opnd_x[LSB +: W]),
                .b  (opnd_y[LSB +: W]),
                .ci (seg_carry[i]),
                .s  (total[LSB +: W]),
                .co (seg_carry[i+1])
            );
        end else begin : g_select
            vbcs_select_seg #(.W(W)) u_sel (
                .a         (opnd_x[LSB +: W]),
                .b         (opnd_y[LSB +: W]),
                .sel_carry (seg_carry[i]),
                .s         (total[LSB +: W]),
                .co        (seg_carry[i+1])
            );
        end
    end

    assign carry_out = seg_carry[SEG_NUM];

endmodule

// File: rtl/vbcs_adder_chk.sv
module vbcs_adder_chk
    import vbcs_pkg::*;
(
    input logic [31:0] opnd_x,
    input logic [31:0] opnd_y,
    input logic        carry_in,
    input logic [31:0] total,
    input logic        carry_out
);

    logic        known;
    logic [32:0] ref_wide;
    logic [5:0]  ref_low;

    always_comb begin
        known    = !$isunknown({opnd_x, opnd_y, carry_in, total, carry_out});
        ref_wide = {1'b0, opnd_x} + {1'b0, opnd_y} + {32'd0, carry_in};
        ref_low  = {1'b0, opnd_x[4:0]} + {1'b0, opnd_y[4:0]} + {5'd0, carry_in};
        if (known) begin
            p_sum_total_r1: assert ({carry_out, total} == ref_wide)
                else $error("R1 wide sum mismatch");
            p_low_seg_r2: assert (total[4:0] == ref_low[4:0])
                else $error("R2 low segment mismatch");
            p_carry_top_r4: assert (carry_out == ref_wide[32])
                else $error("R4 carry out mismatch");
            if (opnd_x == 32'hFFFF_FFFF && opnd_y == 32'd0 && carry_in) begin
                p_wrap_r5: assert (total == 32'd0 && carry_out)
                    else $error("R5 wrap failed");
            end
            if (opnd_x == 32'd0 && opnd_y == 32'd0) begin
                p_zero_r6: assert (total == {31'd0, carry_in} && !carry_out)
                    else $error("R6 zero operands failed");
            end
        end
    end

    for (genvar i = 1; i < SEG_NUM; i++) begin : g_seg_chk
        localparam int LSB = seg_lsb(i);
        localparam int W   = seg_width(i);
        localparam logic [31:0] MASK = 32'((64'd1 << LSB) - 64'd1);

        logic [32:0]  below;
        logic [W-1:0] seg_ref;

        always_comb begin
            below   = {1'b0, opnd_x & MASK} + {1'b0, opnd_y & MASK} + {32'd0, carry_in};
            seg_ref = opnd_x[LSB +: W] + opnd_y[LSB +: W] + W'(below[LSB]);
            if (known) begin
                p_upper_seg_r3: assert (total[LSB +: W] == seg_ref)
                    else $error("R3 upper segment mismatch");
            end
        end
    end

endmodule

bind vbcs_adder vbcs_adder_chk chk_i (
    .opnd_x    (opnd_x),
    .opnd_y    (opnd_y),
    .carry_in  (carry_in),
    .total     (total),
    .carry_out (carry_out)
);

// File: tb/vbcs_adder_tb.sv
module vbcs_adder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_x = '0;
    logic [31:0] opnd_y = '0;
    logic        carry_in = 1'b0;
    logic [31:0] total;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    vbcs_adder dut_i (
        .opnd_x    (opnd_x),
        .opnd_y    (opnd_y),
        .carry_in  (carry_in),
        .total     (total),
        .carry_out (carry_out)
    );

    function automatic logic [32:0] ref_sum(input logic [31:0] x, input logic [31:0] y,
                                            input logic c);
        return {1'b0, x} + {1'b0, y} + {32'd0, c};
    endfunction

    task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive after a rising edge, sample at the next falling edge (R8: zero cycles).
    task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic c,
                         input string req);
        @(posedge clk);
        #1;
        opnd_x   = x;
        opnd_y   = y;
        carry_in = c;
        @(negedge clk);
        check(req, {carry_out, total}, ref_sum(x, y, c));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: zero inputs give zero result (R6).
        check("R6 reset zero", {carry_out, total}, 33'd0);

        apply(32'd0, 32'd0, 1'b1, "R6 zero plus carry");
        apply(32'hFFFF_FFFF, 32'd0, 1'b1, "R5 ones plus carry_in");
        apply(32'hFFFF_FFFF, 32'd1, 1'b0, "R5 ones plus operand");
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R4 max carry out");

        // R7: carry out of bits below each boundary.
        apply(32'h0000_001F, 32'd1, 1'b0, "R7 boundary 5");
        check("R7 exact 2^5", {1'b0, total}, 33'h20);
        apply(32'h0000_0FFF, 32'd0, 1'b1, "R7 boundary 12");
        check("R7 exact 2^12", {1'b0, total}, 33'h1000);
        apply(32'h001F_FFFF, 32'd1, 1'b0, "R7 boundary 21");
        check("R7 exact 2^21", {1'b0, total}, 33'h20_0000);

        // R2: low segment independent of upper bits.
        apply(32'hABCD_E01F, 32'h1234_5601, 1'b1, "R2 low segment");
        check("R2 low bits", {28'd0, total[4:0]}, {28'd0, 5'(5'h1F + 5'h01 + 5'd1)});

        // R1/R3: random vectors with sliced checks.
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] x;
            logic [31:0] y;
            logic        c;
            logic [32:0] e;
            x = $urandom();
            y = $urandom();
            c = 1'($urandom());
            apply(x, y, c, "R1 random");
            e = ref_sum(x, y, c);
            check("R3 seg [11:5]", {26'd0, total[11:5]}, {26'd0, e[11:5]});
            check("R3 seg [20:12]", {24'd0, total[20:12]}, {24'd0, e[20:12]});
            check("R3 seg [31:21]", {22'd0, total[31:21]}, {22'd0, e[31:21]});
            check("R4 carry", {32'd0, carry_out}, {32'd0, e[32]});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule